// File: doc/BRIEF.md
# Flash Coarse-Tune Mode Controller

This block sits between a bank of seven frequency comparators and the loop filter of a fast-locking digital PLL. Each comparator raises a flag when the incoming frequency exceeds its own reference, and the references are evenly spaced over a 2 GHz span. Taken together, the flags form a thermometer code that places the input in one of eight frequency bands. A priority encoder reduces the flags to a 3-bit band number. The band number is captured only at the close of each comparison window. The block also produces the restart strobe that begins the next comparison window.

When a captured band differs from the one held before it, a one-shot fires for a fixed number of clocks. While the one-shot runs, the loop is in coarse mode, and the band number selects the level driven onto the loop filter. When the one-shot expires, control passes to fine phase tracking. A change that arrives while the one-shot is running restarts it at full length. A comparator timeout at the close of a window means the two frequencies are too close to resolve. In that case coarse mode ends at once and the captured band is kept.

Top module: `flash_coarse_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, band_code is 0, coarse_mode is 0 (fine tracking) and cmp_restart is 0.
- R2: cmp_restart is high for exactly one cycle in every WINDOW_CYC cycles. The first such cycle is the WINDOW_CYC-th cycle after reset is released. band_code is updated only at the clock edge that ends a cycle in which cmp_restart is high.
- R3: With cmp_high bit 0 tied to the lowest reference, the captured band equals one plus the index of the highest flag set, or 0 when no flag is set. The thermometer codes 0000000 through 1111111 therefore give bands 0 through 7.
- R4: Flags below the highest set flag have no effect on the band, so a code that is not a thermometer code is encoded by its top set bit alone.
- R5: Flag changes that occur between window closes, and are undone before the next close, leave band_code and coarse_mode unaffected.
- R6: When a window close captures a band different from the held one, coarse_mode is 1 for exactly HOLD_CYC cycles, beginning in the cycle after that close.
- R7: When a window close captures the same band as the held one, no new pulse starts. coarse_mode returns to 0 once the running pulse is used up.
- R8: A band change captured while coarse_mode is 1 restarts the pulse, so coarse_mode stays 1 for HOLD_CYC cycles after that latest change.
- R9: When cmp_timeout is 1 at a window close, band_code keeps its value and coarse_mode is 0 from the next cycle. This takes precedence over any band change present in the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_high | input | 7 | Comparator flags; bit i is high when the input frequency is above reference i |
| cmp_timeout | input | 1 | Comparators could not decide within the window |
| cmp_restart | output | 1 | Last cycle of a comparison window; restarts the comparators |
| band_code | output | 3 | Captured band number, which selects the coarse level |
| coarse_mode | output | 1 | 1 = coarse frequency tracking, 0 = fine phase tracking |

## Verification
The bench builds the block with WINDOW_CYC = 4 and HOLD_CYC = 10. Because the pulse is longer than two windows, a second band change can land while a pulse is still running. This makes the restart behaviour observable, along with a pulse that spans several unchanged windows before it decays. The short window keeps each table step to four clocks. It also allows flags to be changed and restored within a single window, which shows that only the value present at the window close matters.

// File: rtl/flash_tune_pkg.sv
package flash_tune_pkg;

    localparam int N_FLAGS = 7;
    localparam int BAND_W  = $clog2(N_FLAGS + 1);

    typedef logic [BAND_W-1:0]  band_t;
    typedef logic [N_FLAGS-1:0] flags_t;

    typedef enum logic {
        MODE_FINE   = 1'b0,
        MODE_COARSE = 1'b1
    } loop_mode_e;

    // Result of sampling the comparator bank at a window close
    typedef struct packed {
        logic  trig;   // new band accepted, start pulse
        logic  kill;   // timeout, stop coarse tuning
        band_t band;
    } capture_t;

    // Top-most set flag wins; lower flags are discarded.
    function automatic band_t top_flag_band(input flags_t f);
        band_t b;
        b = '0;
        for (int i = 0; i < N_FLAGS; i++) begin
            if (f[i]) b = band_t'(i + 1);
        end
        return b;
    endfunction

endpackage

// File: rtl/cmp_window_timer.sv
module cmp_window_timer #(
    parameter int WINDOW_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int WIN_W = $clog2(WINDOW_CYC + 1);

    logic [WIN_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (win_end) begin
            wcnt <= '0;
        end else begin
            wcnt <= wcnt + 1'b1;
        end
    end

    assign win_end = !rst && (wcnt == WIN_W'(WINDOW_CYC - 1));

    generate
        if (WINDOW_CYC > 1) begin : g_gap
            // R2: the strobe is a single cycle
            p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
                win_end |=> !win_end);
        end
    endgenerate

endmodule

// File: rtl/band_capture.sv
module band_capture
    import flash_tune_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     win_end,
    input  flags_t   flags,
    input  logic     timeout,
    output capture_t cap
);
    band_t band_q;
    band_t band_new;

    assign band_new = top_flag_band(flags);

    always_comb begin
        cap.band = band_q;
        cap.kill = win_end && timeout;
        cap.trig = win_end && !timeout && (band_new != band_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            band_q <= '0;
        end else if (cap.trig) begin
            band_q <= band_new;
        end
    end

    // R2 / R5: the band moves only at a window close
    p_band_only_at_close_r2: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(band_q));

    // R9: a timeout freezes the band
    p_timeout_holds_band_r9: assert property (@(posedge clk) disable iff (rst)
        (win_end && timeout) |=> $stable(band_q));

    // R9: accept and kill never coincide
    p_trig_kill_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(cap.trig && cap.kill));

endmodule

// File: rtl/mode_oneshot.sv
module mode_oneshot
    import flash_tune_pkg::*;
#(
    parameter int HOLD_CYC = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       kill,
    output loop_mode_e mode
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (kill) begin
            remain <= '0;
        end else if (trig) begin
            remain <= CNT_W'(HOLD_CYC);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign mode = (remain != '0) ? MODE_COARSE : MODE_FINE;

    // R6 / R8: a trigger always yields coarse mode next cycle
    p_trig_enters_coarse_r6: assert property (@(posedge clk) disable iff (rst)
        trig |=> (mode == MODE_COARSE));

    // R9: a timeout always leaves coarse mode
    p_kill_exits_coarse_r9: assert property (@(posedge clk) disable iff (rst)
        kill |=> (mode == MODE_FINE));

    // R7: without a trigger, fine mode never turns into coarse mode
    p_no_spurious_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FINE && !trig) |=> (mode == MODE_FINE));

endmodule

// File: rtl/flash_coarse_ctrl.sv
module flash_coarse_ctrl
    import flash_tune_pkg::*;
#(
    parameter int WINDOW_CYC = 4,
    parameter int HOLD_CYC   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_FLAGS-1:0]  cmp_high,
    input  logic                cmp_timeout,
    output logic                cmp_restart,
    output logic [BAND_W-1:0]   band_code,
    output logic                coarse_mode
);
    logic       win_end;
    capture_t   cap;
    loop_mode_e mode;

    cmp_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end)
    );

    band_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end),
        .flags   (cmp_high),
        .timeout (cmp_timeout),
        .cap     (cap)
    );

    mode_oneshot #(.HOLD_CYC(HOLD_CYC)) u_oneshot (
        .clk  (clk),
        .rst  (rst),
        .trig (cap.trig),
        .kill (cap.kill),
        .mode (mode)
    );

    assign cmp_restart = win_end;
    assign band_code   = cap.band;
    assign coarse_mode = (mode == MODE_COARSE);

    // R6: every band step is accompanied by coarse mode
    p_step_means_coarse_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(band_code) |-> coarse_mode);

    // R1: reset state seen one cycle after reset
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (band_code == '0 && !coarse_mode));

endmodule

// File: tb/test_flash_coarse_ctrl.sv
module test_flash_coarse_ctrl;

    localparam int WIN  = 4;
    localparam int HOLD = 10;
    localparam int NV   = 12;

    // {flags[6:0], timeout, band[2:0], mode}
    localparam logic [11:0] VEC [NV] = '{
        {7'b0000000, 1'b0, 3'd0, 1'b0},   // R3 empty code
        {7'b0000111, 1'b0, 3'd3, 1'b1},   // R3/R6 step up
        {7'b0000111, 1'b0, 3'd3, 1'b1},   // R7 pulse still running
        {7'b0000111, 1'b0, 3'd3, 1'b1},   // R7
        {7'b0000111, 1'b0, 3'd3, 1'b0},   // R7 pulse used up
        {7'b1111111, 1'b0, 3'd7, 1'b1},   // R3 full code
        {7'b0011111, 1'b0, 3'd5, 1'b1},   // R8 change while active
        {7'b0010101, 1'b0, 3'd5, 1'b1},   // R4 lower bits ignored
        {7'b0000001, 1'b1, 3'd5, 1'b0},   // R9 timeout holds band
        {7'b0000001, 1'b0, 3'd1, 1'b1},   // R3 lowest band
        {7'b1000000, 1'b1, 3'd1, 1'b0},   // R9 timeout beats change
        {7'b1000000, 1'b0, 3'd7, 1'b1}    // R4 top bit alone
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] cmp_high = '0;
    logic       cmp_timeout = 1'b0;
    logic       cmp_restart;
    logic [2:0] band_code;
    logic       coarse_mode;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    flash_coarse_ctrl #(.WINDOW_CYC(WIN), .HOLD_CYC(HOLD)) i_flash_coarse_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmp_high    (cmp_high),
        .cmp_timeout (cmp_timeout),
        .cmp_restart (cmp_restart),
        .band_code   (band_code),
        .coarse_mode (coarse_mode)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected < 20000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Return 1 ns after the edge that closes the next window
    task automatic wait_close();
        @(negedge clk);
        while (!cmp_restart) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmp_high = '0;
        cmp_timeout = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check("R1 band", band_code, 0);
        check("R1 mode", coarse_mode, 0);
        check("R1 restart", cmp_restart, 0);

        // R2: the first strobe arrives WIN cycles after release
        for (int k = 1; k < WIN; k++) begin
            @(posedge clk); #1;
            check("R2 strobe timing", cmp_restart, (k == WIN - 1) ? 1 : 0);
        end
        @(posedge clk); #1;
        check("R2 strobe single", cmp_restart, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            cmp_high    = VEC[v][11:5];
            cmp_timeout = VEC[v][4];
            wait_close();
            check($sformatf("R3 table band step %0d", v), band_code, int'(VEC[v][3:1]));
            check($sformatf("R6 table mode step %0d", v), coarse_mode, int'(VEC[v][0]));
        end

        // R6: exact pulse length
        do_reset();
        cmp_high = 7'b0001111;
        wait_close();
        begin
            int len = 0;
            while (coarse_mode && len < 100) begin
                len++;
                @(posedge clk); #1;
            end
            check("R6 pulse length", len, HOLD);
        end
        check("R7 band kept after pulse", band_code, 4);

        // R8: retrigger restores full length
        cmp_high = 7'b0000011;
        wait_close();
        cmp_high = 7'b0111111;
        wait_close();
        begin
            int len = 0;
            while (coarse_mode && len < 100) begin
                len++;
                @(posedge clk); #1;
            end
            check("R8 retrigger length", len, HOLD);
        end
        check("R8 band", band_code, 6);

        // R5: a flag change that is undone within a window has no effect
        wait_close();
        cmp_high = 7'b0000001;
        @(posedge clk); #1;
        check("R5 band mid-window", band_code, 6);
        cmp_high = 7'b0111111;
        wait_close();
        check("R5 band after close", band_code, 6);
        check("R5 mode after close", coarse_mode, 0);

        // R1: reset in the middle of a pulse
        cmp_high = 7'b0000001;
        wait_close();
        check("R6 pulse before reset", coarse_mode, 1);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 band in reset", band_code, 0);
        check("R1 mode in reset", coarse_mode, 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule